// File: doc/BRIEF.md
# Daisy-Chained SPI Control Port for a Dual-Channel Line Interface

This block is the serial control slave of a two-channel line-interface device. A host drives a serial clock, an active-low select and a data line. Every transfer opens with a control byte, followed by an address byte and then a data field. The data field is 8 bits for a register and 16 bits for a RAM word. The slave oversamples the serial pins with its own system clock and acts on rising serial-clock edges. It keeps a small register bank and a small RAM for each of its channels.

Up to eight devices can share one select line in a chain. Each device passes the serial stream on through `sdi_thru` to the data input of the next device. While the control byte goes through, each device lowers the channel-ID field by its channel count, two. It does this bit-serially, so the forwarded bit leaves in the same bit period it arrived. Each device therefore serves the channel IDs 0 and 1 as it sees them, and a chain covers 16 channels on one select.

The control flow has three phases. `PH_CTRL` collects the control byte and moves to `PH_ADDR` after its eighth bit. `PH_ADDR` collects the address, loads the read shifter, and moves to `PH_DATA` after its eighth bit. `PH_DATA` shifts 8 or 16 data bits, commits any write on the last bit, and returns to `PH_CTRL`. A high select sends the port back to `PH_CTRL` from any phase.

Top module: `dcspi_port`

## Requirements
- R1: The control byte is received MSB first. Bit 7 set means broadcast. Bit 6 set means read and clear means write. Bit 5 set selects the register bank and clear selects the RAM. Bit 4 has no effect. Bits 3..0 hold the channel ID reversed, with ID bit 0 in bit 3 and ID bit 3 in bit 0.
- R2: A register write is a control byte, an address byte and 8 data bits, all MSB first. The data is stored at that address of the addressed channel.
- R3: During a register read, `sdo_en` is high for the 8 serial bits that follow the address byte. `sdo` carries the stored byte MSB first, and the host samples each bit at a rising serial-clock edge.
- R4: A RAM access (bit 5 clear) carries 16 data bits MSB first, for both write and read.
- R5: A device acts only on a received channel ID of 0 (its first channel) or 1 (its second channel), or on broadcast. A write reaches only the addressed channel, and any other ID leaves `sdo_en` low and changes nothing.
- R6: `sdi_thru` copies `sdi`, except for control-byte bits 3..0. Those bits carry the received channel ID minus 2, modulo 16, in the same reversed order. Bits 7..4 and all address and data bits pass unchanged.
- R7: A broadcast write stores the data in every channel of every device in the chain. A broadcast read leaves `sdo_en` low throughout.
- R8: Raising `cs_n` at any point drops a partial transfer without a write. The next transfer is decoded from a fresh control byte.
- R9: After a data field completes, a new control byte may follow without `cs_n` going high.
- R10: `sdo_en` is low after reset and whenever `cs_n` is high.
- R11: Register addresses of 16 and above, and RAM addresses of 8 and above, read as zero. Writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low shared select |
| sdi | input | 1 | Serial data from the host or from the previous device |
| sdo | output | 1 | Serial read data, valid while `sdo_en` is high |
| sdo_en | output | 1 | Output enable for `sdo`; the line is released when low |
| sdi_thru | output | 1 | Serial stream forwarded to the next device |

## Verification
The hardest behaviour to reach from the ports is the channel-ID rewrite as seen by a second device. A single slave can only show the forwarded bits; it cannot show whether a downstream part really decodes them. The bench therefore chains two instances, with the second one fed only by the first one's `sdi_thru`. Random transfers to IDs 0 to 5 then land on either device or on neither, and each outcome is checked against a four-channel model. Directed cases cover three more situations that random traffic rarely builds: a select dropped after half a data byte, a write and a read back-to-back under one select, and broadcast reads.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic       bcast;
        logic       rd;
        logic       is_reg;
        logic       spare;
        logic [3:0] cid_rev;
    } ctrl_t;

    localparam int CTRL_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int REG_W   = 8;
    localparam int RAM_W   = 16;
    localparam int CID_W   = 4;

    function automatic logic [CID_W-1:0] cid_of(input ctrl_t c);
        return {c.cid_rev[0], c.cid_rev[1], c.cid_rev[2], c.cid_rev[3]};
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[i]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cid_fwd.sv
module cid_fwd #(
    parameter int STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       rise,
    input  logic       cid_phase,
    input  logic [1:0] cid_idx,
    input  logic       sdi_raw,
    input  logic       sdi_smp,
    output logic       sdi_thru
);

    localparam logic [3:0] STEP_V = 4'(STEP);

    logic borrow_q;
    logic k_bit;
    logic borrow_nx;

    // serial subtraction, least significant ID bit first
    assign k_bit     = STEP_V[cid_idx];
    assign borrow_nx = (~sdi_smp & (k_bit | borrow_q)) | (k_bit & borrow_q);
    assign sdi_thru  = cid_phase ? (sdi_raw ^ k_bit ^ borrow_q) : sdi_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            borrow_q <= 1'b0;
        end else if (!active) begin
            borrow_q <= 1'b0;
        end else if (rise) begin
            borrow_q <= cid_phase ? borrow_nx : 1'b0;
        end
    end

endmodule

// File: rtl/chan_store.sv
module chan_store #(
    parameter int CHANS     = 2,
    parameter int REG_DEPTH = 16,
    parameter int RAM_DEPTH = 8,
    parameter int CH_W      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHANS-1:0] wr_mask,
    input  logic             wr_ram,
    input  logic [7:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [CH_W-1:0]  rd_chan,
    input  logic             rd_ram,
    input  logic [7:0]       rd_addr,
    output logic [15:0]      rd_data
);

    localparam int RA_W = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1;
    localparam int MA_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    logic        wr_reg_ok, wr_ram_ok, rd_reg_ok, rd_ram_ok;
    logic [15:0] ch_rd [CHANS];

    assign wr_reg_ok = int'(wr_addr) < REG_DEPTH;
    assign wr_ram_ok = int'(wr_addr) < RAM_DEPTH;
    assign rd_reg_ok = int'(rd_addr) < REG_DEPTH;
    assign rd_ram_ok = int'(rd_addr) < RAM_DEPTH;

    generate
        for (genvar c = 0; c < CHANS; c++) begin : g_chan
            logic [7:0]  regs_q [REG_DEPTH];
            logic [15:0] ram_q  [RAM_DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < REG_DEPTH; i++) regs_q[i] <= '0;
                    for (int j = 0; j < RAM_DEPTH; j++) ram_q[j] <= '0;
                end else if (wr_mask[c]) begin
                    if (wr_ram) begin
                        if (wr_ram_ok) ram_q[wr_addr[MA_W-1:0]] <= wr_data;
                    end else begin
                        if (wr_reg_ok) regs_q[wr_addr[RA_W-1:0]] <= wr_data[7:0];
                    end
                end
            end

            always_comb begin
                if (rd_ram) begin
                    ch_rd[c] = rd_ram_ok ? ram_q[rd_addr[MA_W-1:0]] : 16'h0000;
                end else begin
                    ch_rd[c] = rd_reg_ok ? {8'h00, regs_q[rd_addr[RA_W-1:0]]} : 16'h0000;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = 16'h0000;
        for (int c = 0; c < CHANS; c++) begin
            if (int'(rd_chan) == c) rd_data = ch_rd[c];
        end
    end

endmodule

// File: rtl/dcspi_port.sv
module dcspi_port
    import spi_chain_pkg::*;
#(
    parameter int CHANS       = 2,
    parameter int REG_DEPTH   = 16,
    parameter int RAM_DEPTH   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en,
    output logic sdi_thru
);

    localparam int CNT_W = $clog2(RAM_W) + 1;
    localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1;
    localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] REG_LAST  = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] RAM_LAST  = CNT_W'(RAM_W - 1);
    localparam logic [CNT_W-1:0] CID_FIRST = CNT_W'(CTRL_W - CID_W);

    // pin synchronizers
    logic [2:0] sync_q;
    logic       cs_s, sclk_s, sdi_s, sclk_d, rise;

    spi_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     (sync_q)
    );

    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign sdi_s  = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_d & ~cs_s;

    // state and datapath registers
    phase_e           state_q, state_d;
    logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
    logic [15:0]      shin_q, shin_d, shin_nx;
    ctrl_t            ctrl_q, ctrl_d;
    logic [7:0]       addr_q, addr_d;
    logic [15:0]      rd_sh_q, rd_sh_d;
    logic             data_done;

    logic [CID_W-1:0] cid_rx;
    logic             own_hit;
    logic [CNT_W-1:0] data_last;
    logic [15:0]      rd_data;
    logic [CHANS-1:0] wr_mask;
    logic [15:0]      wr_data;
    logic             cid_phase;

    assign cid_rx    = cid_of(ctrl_q);
    assign own_hit   = int'(cid_rx) < CHANS;
    assign data_last = ctrl_q.is_reg ? REG_LAST : RAM_LAST;
    assign shin_nx   = {shin_q[14:0], sdi_s};

    // next-state logic
    always_comb begin
        state_d   = state_q;
        bitcnt_d  = bitcnt_q;
        shin_d    = shin_q;
        ctrl_d    = ctrl_q;
        addr_d    = addr_q;
        rd_sh_d   = rd_sh_q;
        data_done = 1'b0;
        if (cs_s) begin
            state_d  = PH_CTRL;
            bitcnt_d = '0;
        end else if (rise) begin
            shin_d   = shin_nx;
            bitcnt_d = bitcnt_q + 1'b1;
            unique case (state_q)
                PH_CTRL: begin
                    if (bitcnt_q == CTRL_LAST) begin
                        ctrl_d   = ctrl_t'(shin_nx[7:0]);
                        state_d  = PH_ADDR;
                        bitcnt_d = '0;
                    end
                end
                PH_ADDR: begin
                    if (bitcnt_q == ADDR_LAST) begin
                        addr_d   = shin_nx[7:0];
                        rd_sh_d  = ctrl_q.is_reg ? {rd_data[7:0], 8'h00} : rd_data;
                        state_d  = PH_DATA;
                        bitcnt_d = '0;
                    end
                end
                PH_DATA: begin
                    rd_sh_d = {rd_sh_q[14:0], 1'b0};
                    if (bitcnt_q == data_last) begin
                        data_done = 1'b1;
                        state_d   = PH_CTRL;
                        bitcnt_d  = '0;
                    end
                end
                default: begin
                    state_d  = PH_CTRL;
                    bitcnt_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PH_CTRL;
            bitcnt_q <= '0;
            shin_q   <= '0;
            ctrl_q   <= '0;
            addr_q   <= '0;
            rd_sh_q  <= '0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            shin_q   <= shin_d;
            ctrl_q   <= ctrl_d;
            addr_q   <= addr_d;
            rd_sh_q  <= rd_sh_d;
        end
    end

    // outputs and write strobes
    always_comb begin
        sdo       = rd_sh_q[15];
        sdo_en    = ~cs_n & (state_q == PH_DATA) & ctrl_q.rd & ~ctrl_q.bcast & own_hit;
        cid_phase = ~cs_s & (state_q == PH_CTRL) & (bitcnt_q >= CID_FIRST);
        wr_data   = ctrl_q.is_reg ? {8'h00, shin_nx[7:0]} : shin_nx;
        wr_mask   = '0;
        if (data_done && !ctrl_q.rd) begin
            for (int c = 0; c < CHANS; c++) begin
                wr_mask[c] = ctrl_q.bcast | (cid_rx == CID_W'(c));
            end
        end
    end

    chan_store #(
        .CHANS     (CHANS),
        .REG_DEPTH (REG_DEPTH),
        .RAM_DEPTH (RAM_DEPTH),
        .CH_W      (CH_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_ram  (~ctrl_q.is_reg),
        .wr_addr (addr_q),
        .wr_data (wr_data),
        .rd_chan (cid_rx[CH_W-1:0]),
        .rd_ram  (~ctrl_q.is_reg),
        .rd_addr (shin_nx[7:0]),
        .rd_data (rd_data)
    );

    cid_fwd #(
        .STEP (CHANS)
    ) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (~cs_s),
        .rise      (rise),
        .cid_phase (cid_phase),
        .cid_idx   (bitcnt_q[1:0]),
        .sdi_raw   (sdi),
        .sdi_smp   (sdi_s),
        .sdi_thru  (sdi_thru)
    );

endmodule

// File: rtl/dcspi_port_chk.sv
module dcspi_port_chk
    import spi_chain_pkg::*;
#(
    parameter int CHANS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input phase_e           state_q,
    input logic [4:0]       bitcnt_q,
    input logic             bcast,
    input logic             rd_bit,
    input logic [CHANS-1:0] wr_mask,
    input logic             sdo_en,
    input logic             cid_phase,
    input logic             sdi,
    input logic             sdi_thru
);

    assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state_q == PH_CTRL && bitcnt_q == 5'd0));

    assert_read_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(state_q) == PH_ADDR);

    assert_write_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_mask) |-> (state_q == PH_DATA && !rd_bit));

    assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast |-> $onehot0(wr_mask));

    assert_bcast_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_mask) && bcast) |-> (&wr_mask));

    assert_plain_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cid_phase |-> (sdi_thru == sdi));

    assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q < 5'd16);

endmodule

bind dcspi_port dcspi_port_chk #(.CHANS(CHANS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .state_q   (state_q),
    .bitcnt_q  (bitcnt_q),
    .bcast     (ctrl_q.bcast),
    .rd_bit    (ctrl_q.rd),
    .wr_mask   (wr_mask),
    .sdo_en    (sdo_en),
    .cid_phase (cid_phase),
    .sdi       (sdi),
    .sdi_thru  (sdi_thru)
);

// File: tb/dcspi_port_tb_top.sv
`timescale 1ns/1ps
module dcspi_port_tb_top;

    localparam int HALF = 8;
    localparam int RD   = 16;
    localparam int MD   = 8;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi_h = 1'b0;
    logic sdo_a, en_a, thru_a, sdo_b, en_b, thru_b;
    logic sdo_bus;

    dcspi_port dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi_h),
                      .sdo(sdo_a), .sdo_en(en_a), .sdi_thru(thru_a));
    dcspi_port dev_b (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(thru_a),
                      .sdo(sdo_b), .sdo_en(en_b), .sdi_thru(thru_b));

    assign sdo_bus = en_a ? sdo_a : (en_b ? sdo_b : 1'b1);

    always #10 clk = ~clk;

    int  checks = 0, errors = 0;
    bit  done = 1'b0;
    logic [7:0]  mreg [4][RD];
    logic [15:0] mram [4][MD];

    task automatic chk_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_ctrl(bit bc, bit rd, bit isreg, bit rsv, logic [3:0] cid);
        return {bc, rd, isreg, rsv, cid[0], cid[1], cid[2], cid[3]};
    endfunction

    task automatic send_bit(input logic b, output logic so, output logic en, output logic th);
        sdi_h = b;
        repeat (HALF) @(negedge clk);
        so = sdo_bus; en = en_a | en_b; th = thru_a;
        if (en_a && en_b) chk_eq("R5 two drivers", 16'd1, 16'd0);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic do_txn(input bit bc, input bit rd, input bit isreg, input bit rsv,
                          input logic [3:0] cid, input logic [7:0] addr,
                          input logic [15:0] wdata, input bit keep, input string tag);
        logic [7:0]  ctrl, fwd;
        logic [15:0] rdata, expd;
        logic        so, en, th;
        int          n, en_cnt;
        ctrl = mk_ctrl(bc, rd, isreg, rsv, cid);
        rdata = '0; en_cnt = 0; fwd = '0;
        if (cs_n) begin
            cs_n = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        for (int i = 7; i >= 0; i--) begin send_bit(ctrl[i], so, en, th); fwd[i] = th; end
        for (int i = 7; i >= 0; i--) send_bit(addr[i], so, en, th);
        n = isreg ? 8 : 16;
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(wdata[i], so, en, th);
            rdata = {rdata[14:0], so};
            en_cnt += int'(en);
        end
        // R6: forwarded control byte carries the ID reduced by two
        chk_eq("R6 forwarded control", {8'h00, fwd}, {8'h00, mk_ctrl(bc, rd, isreg, rsv, 4'(cid - 4'd2))});
        if (rd) begin
            if (!bc && cid < 4) begin
                if (isreg) expd = (addr < RD) ? {8'h00, mreg[cid][addr]} : 16'h0;
                else       expd = (addr < MD) ? mram[cid][addr] : 16'h0;
                chk_eq({tag, " read data"}, rdata, expd);
                chk_eq({tag, " enable width"}, 16'(en_cnt), 16'(n));
            end else begin
                chk_eq({tag, " no drive"}, 16'(en_cnt), 16'd0);
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                if (bc || c == int'(cid)) begin
                    if (isreg && addr < RD)  mreg[c][addr] = wdata[7:0];
                    if (!isreg && addr < MD) mram[c][addr] = wdata;
                end
            end
        end
        if (!keep) begin
            cs_n = 1'b1;
            repeat (2 * HALF) @(negedge clk);
            chk_eq("R10 idle enable", {15'd0, en_a | en_b}, 16'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic so, en, th;
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < RD; a++) mreg[c][a] = 8'h00;
            for (int a = 0; a < MD; a++) mram[c][a] = 16'h0000;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk_eq("R10 reset enable", {15'd0, en_a | en_b}, 16'd0);
        sdi_h = 1'b1;
        @(negedge clk);
        chk_eq("R6 idle passthrough", {15'd0, thru_a}, 16'd1);
        sdi_h = 1'b0;

        // R2 / R3 register write and read on the first device
        do_txn(0, 0, 1, 0, 4'd0, 8'd3, 16'h00A5, 0, "R2");
        do_txn(0, 1, 1, 0, 4'd0, 8'd3, 16'h0000, 0, "R3");
        // R5 second channel kept apart from the first
        do_txn(0, 0, 1, 0, 4'd1, 8'd3, 16'h003C, 0, "R5");
        do_txn(0, 1, 1, 0, 4'd0, 8'd3, 16'h0000, 0, "R5");
        do_txn(0, 1, 1, 0, 4'd1, 8'd3, 16'h0000, 0, "R5");
        // R4 RAM on the second device, reached through the chain (R6)
        do_txn(0, 0, 0, 0, 4'd2, 8'd5, 16'hBEEF, 0, "R4");
        do_txn(0, 1, 0, 0, 4'd2, 8'd5, 16'h0000, 0, "R4");
        do_txn(0, 1, 0, 0, 4'd3, 8'd5, 16'h0000, 0, "R6");
        // R1 spare bit ignored
        do_txn(0, 0, 1, 1, 4'd3, 8'd9, 16'h005A, 0, "R1");
        do_txn(0, 1, 1, 1, 4'd3, 8'd9, 16'h0000, 0, "R1");
        // R7 broadcast write, then broadcast read stays silent
        do_txn(1, 0, 1, 0, 4'd0, 8'd7, 16'h0077, 0, "R7");
        for (int c = 0; c < 4; c++) do_txn(0, 1, 1, 0, 4'(c), 8'd7, 16'h0, 0, "R7");
        do_txn(1, 1, 1, 0, 4'd0, 8'd7, 16'h0, 0, "R7");
        // R11 out of range
        do_txn(0, 0, 1, 0, 4'd0, 8'd20, 16'h00EE, 0, "R11");
        do_txn(0, 1, 1, 0, 4'd0, 8'd20, 16'h0000, 0, "R11");
        do_txn(0, 1, 0, 0, 4'd1, 8'd8, 16'h0000, 0, "R11");

        // R8 abort in the middle of the data byte
        begin
            logic [7:0] c8;
            c8 = mk_ctrl(0, 0, 1, 0, 4'd0);
            cs_n = 1'b0;
            repeat (HALF) @(negedge clk);
            for (int i = 7; i >= 0; i--) send_bit(c8[i], so, en, th);
            for (int i = 7; i >= 0; i--) send_bit(3'd3 == 3'(i) ? 1'b0 : (i < 2), so, en, th);
            for (int i = 0; i < 4; i++) send_bit(1'b1, so, en, th);
            cs_n = 1'b1;
            repeat (2 * HALF) @(negedge clk);
        end
        do_txn(0, 1, 1, 0, 4'd0, 8'd3, 16'h0000, 0, "R8");

        // R9 write then read under one select
        do_txn(0, 0, 0, 0, 4'd1, 8'd2, 16'h1234, 1, "R9");
        do_txn(0, 1, 0, 0, 4'd1, 8'd2, 16'h0000, 1, "R9");
        do_txn(0, 1, 1, 0, 4'd2, 8'd9, 16'h0000, 0, "R9");

        // random mix
        void'($urandom(32'd2024));
        for (int k = 0; k < 40; k++) begin
            bit bc, rd, isreg;
            logic [3:0] cid;
            logic [7:0] addr;
            logic [15:0] wd;
            bc    = ($urandom_range(0, 4) == 0);
            rd    = $urandom_range(0, 1);
            isreg = $urandom_range(0, 1);
            cid   = 4'($urandom_range(0, 5));
            addr  = 8'($urandom_range(0, 19));
            wd    = 16'($urandom);
            if (isreg) wd[15:8] = 8'h00;
            do_txn(bc, rd, isreg, 0, cid, addr, wd, 0, rd ? "R3 R4 R5" : "R2 R4 R7");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule